// File: doc/BRIEF.md
# Eight-Slot TDM Clock-Master Receiver

This block is the timing master of a serial audio input link that carries eight channel slots per sample period. It runs from a system clock at 512 times the sample rate. From that clock it produces a bit clock at 256 times the sample rate and a one-bit-period frame marker. It samples one serial data line and sorts the bits into eight channel words. The word length is 16, 20 or 24 bits, chosen by an input that the block reads once per frame.

Six of the eight slots carry samples for local converters. When a frame ends, the block presents those six words on one wide parallel output together with a single-cycle valid strobe. The other two slots carry one left/right pair for a companion converter. The block holds that pair and sends it out during the next frame on a separate three-wire stereo port (word select, bit clock, data) in standard I2S framing.

Top module: `tdm_master_rx`

## Requirements
- R1: While `rst` is high, every output is held at 0, and the frame position is held at its start.
- R2: `bclk_o` changes level on every system clock cycle. Each frame has exactly 256 rising edges of `bclk_o` (512 system cycles).
- R3: `fsync_o` goes high together with a rising edge of `bclk_o` and stays high for exactly one bit period (2 system cycles), at the start of slot 0.
- R4: `ser_in` is sampled where `bclk_o` falls. The bit launched at rising edge number g after the frame marker (g = 1..256) is bit 31-p of slot s, with 32*s + p = g - 1 (MSB first, p = 0 is the MSB). The slots are, in order, L0, L1, L2, auxiliary L, R0, R1, R2, auxiliary R.
- R5: `wlen_sel` 00 selects 16 bits, 01 selects 20 bits, and 10 or 11 select 24 bits. Only the top N bits of each 32-bit slot are kept. They are left-aligned in a 24-bit word with zero LSBs, and the remaining slot bits have no effect.
- R6: `wlen_sel` is captured only during reset and at the system cycle where a new frame begins. A change at any other time affects only the following frame.
- R7: After each complete frame, `pcm_valid_o` is high for exactly one system cycle, during the first cycle of the next frame. `pcm_o[24n+23:24n]` carries internal channel n, in the order L0, L1, L2, R0, R1, R2.
- R8: `fwd_bclk_o` has a period of 8 system cycles, with 64 rising edges per frame. `fwd_ws_o` is low for the first 32 forwarding bits (left) and high for the last 32 (right). `fwd_ws_o` and `fwd_sd_o` change only where `fwd_bclk_o` falls.
- R9: The auxiliary pair received in frame F goes out on `fwd_sd_o` during frame F+1 as 24-bit words, MSB first. Each MSB starts one forwarding bit after the matching `fwd_ws_o` edge, and positions 24..31 of each half are 0. During the first frame after reset, zeros are sent.
- R10: `pcm_o` changes only in the cycle where `pcm_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 512 times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial TDM data from the transmitter |
| wlen_sel | input | 2 | Word length select (00: 16, 01: 20, 1x: 24) |
| bclk_o | output | 1 | TDM bit clock |
| fsync_o | output | 1 | TDM frame marker |
| pcm_o | output | 144 | Six internal channel words, 24 bits each |
| pcm_valid_o | output | 1 | One-cycle strobe when `pcm_o` is updated |
| fwd_ws_o | output | 1 | Forwarding port word select (low = left) |
| fwd_bclk_o | output | 1 | Forwarding port bit clock |
| fwd_sd_o | output | 1 | Forwarding port serial data |

## Verification
The assertions check the waveform rules on every cycle:
- the bit clock toggles on every cycle;
- the frame marker starts on a bit-clock rise and is exactly one bit long;
- the valid strobe is one cycle long, falls inside the marker and is the only time the parallel output moves;
- the forwarding word select and data change only on falling forwarding-clock edges.

Only the bench scenarios can show where bits go:
- which serial bit lands in which slot and position;
- zero-fill for each word length;
- that a length change in mid-frame takes effect one frame late;
- that the auxiliary pair comes back out one frame later, at the right forwarding positions.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;

  typedef enum logic [1:0] {
    WLEN_16  = 2'b00,
    WLEN_20  = 2'b01,
    WLEN_24  = 2'b10,
    WLEN_24X = 2'b11
  } wlen_e;

  // Number of data bits kept per slot for a word-length code
  function automatic int unsigned wlen_bits(input logic [1:0] code);
    case (wlen_e'(code))
      WLEN_16: return 16;
      WLEN_20: return 20;
      default: return 24;
    endcase
  endfunction

  // Slot holding internal channel n: the left group sits below the
  // left auxiliary slot, the right group directly above it
  function automatic int unsigned int_slot(input int unsigned n, input int unsigned slots);
    return (n < slots / 2 - 1) ? n : n + 1;
  endfunction

endpackage

// File: rtl/tdmrx_clkgen.sv
module tdmrx_clkgen #(
  parameter int FRAME_CYC = 512,
  parameter int CW        = $clog2(FRAME_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          run,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          bclk,
  output logic          fsync
);

  localparam logic [CW-1:0] LAST = CW'(FRAME_CYC - 1);

  // The first cycle after reset shows position zero; after that, step
  always_comb begin
    if (!run || cnt == LAST) cnt_nxt = '0;
    else                     cnt_nxt = cnt + 1'b1;
  end

  // Outputs decode the next count so they line up with cnt
  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      cnt   <= '0;
      bclk  <= 1'b0;
      fsync <= 1'b0;
    end else begin
      run   <= 1'b1;
      cnt   <= cnt_nxt;
      bclk  <= ~cnt_nxt[0];
      fsync <= (cnt_nxt[CW-1:1] == '0);
    end
  end

endmodule

// File: rtl/tdmrx_deser.sv
module tdmrx_deser
  import tdmrx_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int SLOT_BITS = 32,
  parameter int MAX_W     = 24,
  parameter int CW        = 9,
  localparam int NINT     = SLOTS - 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic [CW-1:0]         cnt,
  input  logic                  ser_in,
  input  logic [1:0]            wlen_sel,
  output logic [NINT*MAX_W-1:0] pcm,
  output logic                  pcm_valid,
  output logic [MAX_W-1:0]      aux_l,
  output logic [MAX_W-1:0]      aux_r
);

  localparam int GW     = CW - 1;
  localparam int PW     = $clog2(SLOT_BITS);
  localparam int SW     = GW - PW;
  localparam int LW     = $clog2(MAX_W + 1);
  localparam int AUX_LS = SLOTS / 2 - 1;
  localparam int AUX_RS = SLOTS - 1;
  localparam logic [CW-1:0] LAST = {CW{1'b1}};

  logic [MAX_W-1:0] words [SLOTS];
  logic [MAX_W-1:0] acc, acc_nxt;
  logic [LW-1:0]    wbits;
  logic [GW-1:0]    kbit;
  logic [SW-1:0]    slot;
  logic [PW-1:0]    pos;
  logic             smp;
  logic             commit;

  // Data lags the frame marker by one bit period
  assign kbit   = cnt[CW-1:1] - 1'b1;
  assign slot   = kbit[GW-1:PW];
  assign pos    = kbit[PW-1:0];
  assign smp    = run && !cnt[0];
  assign commit = smp && (int'(pos) == MAX_W - 1);

  always_comb begin
    acc_nxt = (pos == '0) ? '0 : acc;
    for (int b = 0; b < MAX_W; b++) begin
      if (int'(pos) == b && b < int'(wbits)) acc_nxt[MAX_W-1-b] = ser_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      acc <= '0;
    else if (smp) acc <= acc_nxt;
  end

  // Slot store: one entry written per slot, no reset
  always_ff @(posedge clk) begin
    if (commit) words[slot] <= acc_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcm       <= '0;
      pcm_valid <= 1'b0;
      aux_l     <= '0;
      aux_r     <= '0;
      wbits     <= LW'(wlen_bits(wlen_sel));
    end else begin
      pcm_valid <= 1'b0;
      if (run && cnt == LAST) begin
        pcm_valid <= 1'b1;
        for (int n = 0; n < NINT; n++) begin
          pcm[n*MAX_W +: MAX_W] <= words[int_slot(n, SLOTS)];
        end
        aux_l <= words[AUX_LS];
        aux_r <= words[AUX_RS];
        wbits <= LW'(wlen_bits(wlen_sel));
      end
    end
  end

endmodule

// File: rtl/tdmrx_fwd.sv
module tdmrx_fwd #(
  parameter int FRAME_CYC = 512,
  parameter int HALF      = 32,
  parameter int MAX_W     = 24,
  parameter int CW        = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    cnt_nxt,
  input  logic [MAX_W-1:0] aux_l,
  input  logic [MAX_W-1:0] aux_r,
  output logic             ws,
  output logic             sclk,
  output logic             sd
);

  localparam int FBITS = 2 * HALF;
  localparam int BITC  = FRAME_CYC / FBITS;

  logic ws_n, sclk_n, sd_n;

  always_comb begin
    int jb, q, p;
    logic [MAX_W-1:0] w;
    jb     = int'(cnt_nxt) / BITC;
    sclk_n = (int'(cnt_nxt) % BITC) >= BITC / 2;
    ws_n   = jb >= HALF;
    // One-bit delay after each word select edge
    q      = (jb + FBITS - 1) % FBITS;
    p      = q % HALF;
    w      = (q >= HALF) ? aux_r : aux_l;
    sd_n   = 1'b0;
    for (int b = 0; b < MAX_W; b++) begin
      if (p == b) sd_n = w[MAX_W-1-b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws   <= 1'b0;
      sclk <= 1'b0;
      sd   <= 1'b0;
    end else begin
      ws   <= ws_n;
      sclk <= sclk_n;
      sd   <= sd_n;
    end
  end

endmodule

// File: rtl/tdm_master_rx.sv
module tdm_master_rx #(
  parameter int SLOTS     = 8,
  parameter int SLOT_BITS = 32,
  parameter int MAX_W     = 24,
  parameter int FWD_HALF  = 32,
  localparam int PCM_W    = (SLOTS - 2) * MAX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic [1:0]       wlen_sel,
  output logic             bclk_o,
  output logic             fsync_o,
  output logic [PCM_W-1:0] pcm_o,
  output logic             pcm_valid_o,
  output logic             fwd_ws_o,
  output logic             fwd_bclk_o,
  output logic             fwd_sd_o
);

  localparam int FRAME_CYC = 2 * SLOTS * SLOT_BITS;
  localparam int CW        = $clog2(FRAME_CYC);

  logic          run;
  logic [CW-1:0] cnt, cnt_nxt;
  logic [MAX_W-1:0] aux_l, aux_r;

  tdmrx_clkgen #(.FRAME_CYC(FRAME_CYC), .CW(CW)) u_clk (
    .clk(clk), .rst(rst), .run(run), .cnt(cnt), .cnt_nxt(cnt_nxt),
    .bclk(bclk_o), .fsync(fsync_o)
  );

  tdmrx_deser #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .MAX_W(MAX_W), .CW(CW)) u_deser (
    .clk(clk), .rst(rst), .run(run), .cnt(cnt), .ser_in(ser_in),
    .wlen_sel(wlen_sel), .pcm(pcm_o), .pcm_valid(pcm_valid_o),
    .aux_l(aux_l), .aux_r(aux_r)
  );

  tdmrx_fwd #(.FRAME_CYC(FRAME_CYC), .HALF(FWD_HALF), .MAX_W(MAX_W), .CW(CW)) u_fwd (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .aux_l(aux_l), .aux_r(aux_r),
    .ws(fwd_ws_o), .sclk(fwd_bclk_o), .sd(fwd_sd_o)
  );

endmodule

// File: rtl/tdmrx_checker.sv
module tdmrx_checker #(
  parameter int PCM_W = 144
) (
  input logic             clk,
  input logic             rst,
  input logic             bclk_o,
  input logic             fsync_o,
  input logic [PCM_W-1:0] pcm_o,
  input logic             pcm_valid_o,
  input logic             fwd_ws_o,
  input logic             fwd_bclk_o,
  input logic             fwd_sd_o
);

  AST_BCLK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bclk_o != $past(bclk_o))); // R2

  AST_FS_ON_BCLK_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_o) |-> $rose(bclk_o)); // R3

  AST_FS_HOLDS_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_o) |=> fsync_o); // R3

  AST_FS_ENDS: assert property (@(posedge clk) disable iff (rst)
    (fsync_o && $past(fsync_o)) |=> !fsync_o); // R3

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pcm_valid_o |=> !pcm_valid_o); // R7

  AST_VALID_AT_START: assert property (@(posedge clk) disable iff (rst)
    pcm_valid_o |-> (fsync_o && bclk_o)); // R7

  AST_PCM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pcm_valid_o |-> $stable(pcm_o)); // R10

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(fwd_ws_o) |-> $fell(fwd_bclk_o)); // R8

  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(fwd_sd_o) |-> $fell(fwd_bclk_o)); // R8

endmodule

bind tdm_master_rx tdmrx_checker #(.PCM_W(PCM_W)) u_tdmrx_checker (
  .clk(clk), .rst(rst), .bclk_o(bclk_o), .fsync_o(fsync_o), .pcm_o(pcm_o),
  .pcm_valid_o(pcm_valid_o), .fwd_ws_o(fwd_ws_o), .fwd_bclk_o(fwd_bclk_o),
  .fwd_sd_o(fwd_sd_o)
);

// File: tb/test_tdm_master_rx.sv
module test_tdm_master_rx;

  localparam int NF = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_in = 1'b0;
  logic [1:0]   wlen_sel = 2'b10;
  logic         bclk_o, fsync_o, pcm_valid_o, fwd_ws_o, fwd_bclk_o, fwd_sd_o;
  logic [143:0] pcm_o;

  int checks = 0;
  int fails  = 0;
  int fidx   = -1;
  int rises  = 0;
  int jc     = 0;
  int vseen  = 0;
  logic pb = 1'b0, pib = 1'b0, pfs = 1'b0;
  bit fin = 1'b0;

  always #10 clk = ~clk;

  tdm_master_rx i_tdm_master_rx (
    .clk(clk), .rst(rst), .ser_in(ser_in), .wlen_sel(wlen_sel),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .pcm_o(pcm_o), .pcm_valid_o(pcm_valid_o),
    .fwd_ws_o(fwd_ws_o), .fwd_bclk_o(fwd_bclk_o), .fwd_sd_o(fwd_sd_o)
  );

  function automatic logic [31:0] slotval(input int f, input int s);
    logic [31:0] v;
    v = 32'(f) * 32'h9E3779B1 + 32'(s) * 32'h7F4A7C15 + 32'h0BADF00D;
    return v ^ (v >> 15);
  endfunction

  function automatic logic [1:0] wsel_of(input int f);
    case (f % 4)
      0:       return 2'b10;
      1:       return 2'b00;
      2:       return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [23:0] keep(input logic [31:0] v, input logic [1:0] ws);
    int n;
    n = (ws == 2'b00) ? 16 : (ws == 2'b01) ? 20 : 24;
    return v[31:8] & (24'hFFFFFF << (24 - n));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (frame %0d)", tag, act, exp, fidx);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    wlen_sel = wsel_of(0);
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 bclk", 32'(bclk_o), 0);
    chk("R1 fsync", 32'(fsync_o), 0);
    chk("R1 valid", 32'(pcm_valid_o), 0);
    chk("R1 pcm", 32'(pcm_o != '0), 0);
    chk("R1 fwd", 32'({fwd_ws_o, fwd_bclk_o, fwd_sd_o}), 0);
    rst = 1'b0;
    wait (fidx == NF);
    repeat (20) @(negedge clk);
    chk("R7 valid count", 32'(vseen), 32'(NF));
    fin = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (fsync_o && !pfs) begin
          if (fidx >= 0) begin
            chk("R2 bclk rises per frame", 32'(rises), 256);
            chk("R8 fwd bits per frame", 32'(jc), 64);
          end
          fidx++;
          rises = 0;
          jc = 0;
        end
        if (bclk_o && !pb) begin
          int g, k, f;
          g = rises;
          rises++;
          chk("R3 fsync at slot 0 start", 32'(fsync_o), 32'(g == 0));
          k = (g + 255) % 256;
          f = (g == 0) ? fidx - 1 : fidx;
          ser_in = slotval(f, k / 32)[31 - (k % 32)];
          // R6: the select moves in mid-frame; the change is due next frame
          if (g == 128) wlen_sel = wsel_of(fidx + 1);
          if (g == 100 && fidx >= 1)
            chk("R10 pcm held", 32'(pcm_o[23:0]), 32'(keep(slotval(fidx - 1, 0), wsel_of(fidx - 1))));
        end
        if (pcm_valid_o) begin
          vseen++;
          for (int n = 0; n < 6; n++) begin
            int s;
            s = (n < 3) ? n : n + 1;
            chk("R4 R5 R6 R7 channel word", 32'(pcm_o[n*24 +: 24]),
                32'(keep(slotval(fidx - 1, s), wsel_of(fidx - 1))));
          end
        end
        if (fwd_bclk_o && !pib) begin
          int j, q, p;
          logic [23:0] w;
          logic eb;
          j = jc;
          jc++;
          chk("R8 word select", 32'(fwd_ws_o), 32'(j >= 32));
          q = (j + 63) % 64;
          p = q % 32;
          w = (fidx == 0) ? 24'h0 : keep(slotval(fidx - 1, (q >= 32) ? 7 : 3), wsel_of(fidx - 1));
          eb = (p < 24) ? w[23 - p] : 1'b0;
          chk("R9 forwarded bit", 32'(fwd_sd_o), 32'(eb));
        end
        pb  = bclk_o;
        pib = fwd_bclk_o;
        pfs = fsync_o;
      end
    end
  end

endmodule